// File: doc/BRIEF.md
# Hashed MMU translation sequencer

This block turns one 32-bit effective address into a real address, or into a fault. Each request carries an access kind (fetch, load or store), a privilege flag, a translation-enable flag and an access class (integer, floating, reservation, cache operation, external control). The block holds a file of segment registers that software loads through a write port. It asks an external block-translation unit first. If that unit misses, it reads the selected segment register. It then either settles the access itself (direct-store segments, no-execute fetches) or asks an external page-table walker for the matching page entry. It decodes page protection from the entry it gets back.

The result is a real address, a three-bit permission mask, and either success or a fault. A fault carries a kind, a 32-bit syndrome and a fault address. The request and both side channels use valid handshakes. One request is in flight at a time. Completion is a one-cycle `done` pulse, and the result outputs hold their values until the next completion.

Top module: `xlate_seq`

## Requirements
- R1: With `req_xlate_on`=0 the access completes with `ok`=1, `ra` equal to the effective address and `perm`=3'b111. Neither side channel is used. Encodings: `perm` bit 0 is read, bit 1 write, bit 2 execute. `req_kind` is 0 fetch, 1 load, 2 store. `req_class` is 0 integer, 1 floating, 2 reservation, 3 cache op, 4 external. `flt_kind` is 0 none, 1 instruction, 2 data, 3 alignment.
- R2: With translation on, the block-translation unit is asked first. On a hit whose `blk_rsp_perm` covers the access, the result is `blk_rsp_ra` with that mask. On a hit that lacks the right, the access takes the permission fault of R10. After a hit, no segment step and no walk follow.
- R3: The segment register is chosen by effective address bits 31:28. Its fields are: bit 31 direct-store, bit 30 supervisor key, bit 29 user key, bit 28 no-execute, bits 27:0 the identifier passed to the walker. A user access uses bit 29 as its key and a supervisor access uses bit 30.
- R4: In a direct-store segment a fetch gets an instruction fault with code 0x10000000. A floating access gets an alignment fault with code 0 and the effective address. A cache-op access succeeds with `ra` equal to the effective address and the direct-store permissions of R6.
- R5: In a direct-store segment a reservation access gets a data fault with code 0x04000000 (load) or 0x06000000 (store). An external-control access gets a data fault with code 0x04100000 (load) or 0x06100000 (store).
- R6: In a direct-store segment an integer access is given read/write when the key is 1 and read-only when the key is 0. If granted, it succeeds with `ra` equal to the effective address. If denied, it faults with code 0x08000000 (load) or 0x0A000000 (store).
- R7: A fetch from a non-direct-store segment with the no-execute bit set gets an instruction fault with code 0x10000000, and no walk is requested.
- R8: Page rights come from the entry's two-bit field `walk_rsp_pp`. Key 0: read/write for 0, 1 and 2, read-only for 3. Key 1: none for 0, read-only for 1 and 3, read/write for 2. Execute is added only when the segment no-execute bit is clear. On success `ra` is `walk_rsp_rpn` joined to effective address bits 11:0.
- R9: A walk that finds no entry gives an instruction fault with code 0x40000000 for a fetch. For a load or store it gives a data fault with code 0x40000000 or 0x42000000 respectively.
- R10: A permission violation gives an instruction fault with code 0x08000000 for a fetch, or a data fault with code 0x08000000 (load) or 0x0A000000 (store). Every data or alignment fault reports the effective address on `flt_addr`; an instruction fault reports 0. Any fault reports `ra`=0 and `perm`=0.
- R11: A load that succeeds through a page entry whose changed flag `walk_rsp_chg` is 0 returns its permissions with write removed.
- R12: `req_ready` is high only while idle. `done` is high for exactly one cycle per request. The result outputs hold until the next completion. A synchronous reset returns the block to idle with no request outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New translation request |
| req_ready | output | 1 | Block is idle and takes a request |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| req_user | input | 1 | 1 for user privilege |
| req_xlate_on | input | 1 | Translation enabled |
| req_class | input | 3 | Access class |
| seg_we | input | 1 | Segment register write enable |
| seg_idx | input | 4 | Segment register index |
| seg_wdata | input | 32 | Segment register write data |
| blk_req_valid | output | 1 | Query to the block-translation unit |
| blk_req_ea | output | 32 | Address being queried |
| blk_req_kind | output | 2 | Access kind being queried |
| blk_req_user | output | 1 | Privilege being queried |
| blk_rsp_valid | input | 1 | Block-translation answer |
| blk_rsp_hit | input | 1 | Block entry matched |
| blk_rsp_ra | input | 32 | Real address from block entry |
| blk_rsp_perm | input | 3 | Rights of the block entry |
| walk_req_valid | output | 1 | Request to the page-table walker |
| walk_req_vsid | output | 28 | Segment identifier field |
| walk_req_ea | output | 32 | Effective address to walk |
| walk_rsp_valid | input | 1 | Walker answer |
| walk_rsp_found | input | 1 | Matching page entry found |
| walk_rsp_rpn | input | 20 | Real page number |
| walk_rsp_pp | input | 2 | Page protection field |
| walk_rsp_chg | input | 1 | Page changed flag |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Access granted |
| ra | output | 32 | Real address |
| perm | output | 3 | Returned rights |
| flt_kind | output | 2 | Fault kind |
| flt_code | output | 32 | Fault syndrome |
| flt_addr | output | 32 | Faulting address |

## Verification
The assertions assume the two side units are well behaved. Each answers only while its own request valid is high and answers once per request. Segment registers are not rewritten while a request is in flight. The bench respects all of this. It loads the selected segment register before raising `req_valid`. It drives each side response for exactly one cycle, and only after seeing the matching request valid. It keeps response fields constant for the whole request.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int XW      = 32;
  localparam int PG_BITS = 12;

  // segment register field positions
  localparam int SEG_T  = 31;
  localparam int SEG_KS = 30;
  localparam int SEG_KP = 29;
  localparam int SEG_NX = 28;

  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_LOAD  = 2'd1;
  localparam logic [1:0] ACC_STORE = 2'd2;

  localparam logic [2:0] CLS_INT   = 3'd0;
  localparam logic [2:0] CLS_FLT   = 3'd1;
  localparam logic [2:0] CLS_RSV   = 3'd2;
  localparam logic [2:0] CLS_CACHE = 3'd3;
  localparam logic [2:0] CLS_EXT   = 3'd4;

  localparam logic [1:0] FK_NONE  = 2'd0;
  localparam logic [1:0] FK_INSTR = 2'd1;
  localparam logic [1:0] FK_DATA  = 2'd2;
  localparam logic [1:0] FK_ALIGN = 2'd3;

  localparam logic [2:0] PM_R = 3'b001;
  localparam logic [2:0] PM_W = 3'b010;
  localparam logic [2:0] PM_X = 3'b100;

  localparam logic [31:0] C_NOEXEC = 32'h1000_0000;
  localparam logic [31:0] C_MISS   = 32'h4000_0000;
  localparam logic [31:0] C_PROT   = 32'h0800_0000;
  localparam logic [31:0] C_RSV    = 32'h0400_0000;
  localparam logic [31:0] C_EXT    = 32'h0410_0000;
  localparam logic [31:0] C_STBIT  = 32'h0200_0000;

  typedef struct packed {
    logic          ok;
    logic [XW-1:0] ra;
    logic [2:0]    perm;
    logic [1:0]    fk;
    logic [31:0]   code;
    logic [XW-1:0] addr;
  } xres_t;

  function automatic logic [2:0] need_of(input logic [1:0] kind);
    case (kind)
      ACC_FETCH: need_of = PM_X;
      ACC_STORE: need_of = PM_W;
      default:   need_of = PM_R;
    endcase
  endfunction

  function automatic logic [31:0] dcode(input logic [31:0] base, input logic st);
    dcode = base | (st ? C_STBIT : 32'h0);
  endfunction
endpackage

// File: rtl/seg_file.sv
module seg_file #(
  parameter int SEG_CNT = 16,
  parameter int DW      = 32,
  localparam int IW     = $clog2(SEG_CNT)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [SEG_CNT];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/prot_decode.sv
module prot_decode (
  input  logic       key,
  input  logic [1:0] pp,
  input  logic       nx,
  output logic [2:0] pm
);
  import xlate_pkg::*;

  logic [2:0] rw;

  always_comb begin
    if (!key) begin
      rw = (pp == 2'd3) ? PM_R : (PM_R | PM_W);
    end else begin
      case (pp)
        2'd0:    rw = 3'b000;
        2'd2:    rw = PM_R | PM_W;
        default: rw = PM_R;
      endcase
    end
    pm = rw | (nx ? 3'b000 : PM_X);
  end

  always_comb begin
    if (key && pp == 2'd0) a_key1_pp0_r8: assert ((pm & (PM_R | PM_W)) == 3'b000);
  end
endmodule

// File: rtl/xlate_seq.sv
module xlate_seq #(
  parameter int SEG_CNT = 16,
  parameter int VSID_W  = 28
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  req_valid,
  output logic                                  req_ready,
  input  logic [xlate_pkg::XW-1:0]              req_ea,
  input  logic [1:0]                            req_kind,
  input  logic                                  req_user,
  input  logic                                  req_xlate_on,
  input  logic [2:0]                            req_class,
  input  logic                                  seg_we,
  input  logic [$clog2(SEG_CNT)-1:0]            seg_idx,
  input  logic [xlate_pkg::XW-1:0]              seg_wdata,
  output logic                                  blk_req_valid,
  output logic [xlate_pkg::XW-1:0]              blk_req_ea,
  output logic [1:0]                            blk_req_kind,
  output logic                                  blk_req_user,
  input  logic                                  blk_rsp_valid,
  input  logic                                  blk_rsp_hit,
  input  logic [xlate_pkg::XW-1:0]              blk_rsp_ra,
  input  logic [2:0]                            blk_rsp_perm,
  output logic                                  walk_req_valid,
  output logic [VSID_W-1:0]                     walk_req_vsid,
  output logic [xlate_pkg::XW-1:0]              walk_req_ea,
  input  logic                                  walk_rsp_valid,
  input  logic                                  walk_rsp_found,
  input  logic [xlate_pkg::XW-xlate_pkg::PG_BITS-1:0] walk_rsp_rpn,
  input  logic [1:0]                            walk_rsp_pp,
  input  logic                                  walk_rsp_chg,
  output logic                                  done,
  output logic                                  ok,
  output logic [xlate_pkg::XW-1:0]              ra,
  output logic [2:0]                            perm,
  output logic [1:0]                            flt_kind,
  output logic [31:0]                           flt_code,
  output logic [xlate_pkg::XW-1:0]              flt_addr
);
  import xlate_pkg::*;

  localparam int SEL_W = $clog2(SEG_CNT);

  typedef enum logic [1:0] {ST_IDLE, ST_BLK, ST_WALK} st_e;

  st_e           state;
  logic [XW-1:0] ea_q;
  logic [1:0]    kind_q;
  logic          user_q;
  logic [2:0]    cls_q;
  xres_t         out_q;
  logic          done_q;

  logic [XW-1:0] seg_val;
  logic          key, nx, is_fetch, is_store;
  logic [2:0]    need, ds_perm, pg_perm;
  xres_t         blk_res, seg_res, walk_res;
  logic          seg_final;

  seg_file #(.SEG_CNT(SEG_CNT), .DW(XW)) u_seg (
    .clk   (clk),
    .we    (seg_we),
    .widx  (seg_idx),
    .wdata (seg_wdata),
    .ridx  (ea_q[XW-1 -: SEL_W]),
    .rdata (seg_val)
  );

  prot_decode u_prot (
    .key (key),
    .pp  (walk_rsp_pp),
    .nx  (nx),
    .pm  (pg_perm)
  );

  function automatic xres_t f_ok(input logic [XW-1:0] a, input logic [2:0] pm);
    xres_t r;
    r      = '0;
    r.ok   = 1'b1;
    r.ra   = a;
    r.perm = pm;
    return r;
  endfunction

  function automatic xres_t f_flt(input logic [1:0] fk, input logic [31:0] code,
                                  input logic [XW-1:0] a);
    xres_t r;
    r      = '0;
    r.fk   = fk;
    r.code = code;
    r.addr = (fk == FK_INSTR) ? '0 : a;
    return r;
  endfunction

  always_comb begin
    key      = user_q ? seg_val[SEG_KP] : seg_val[SEG_KS];
    nx       = seg_val[SEG_NX];
    is_fetch = (kind_q == ACC_FETCH);
    is_store = (kind_q == ACC_STORE);
    need     = need_of(kind_q);
    ds_perm  = key ? (PM_R | PM_W) : PM_R;

    // block-translation outcome
    if ((need & ~blk_rsp_perm) != 3'b000)
      blk_res = is_fetch ? f_flt(FK_INSTR, C_PROT, ea_q)
                         : f_flt(FK_DATA, dcode(C_PROT, is_store), ea_q);
    else
      blk_res = f_ok(blk_rsp_ra, blk_rsp_perm);

    // segment step
    seg_final = 1'b1;
    seg_res   = '0;
    if (seg_val[SEG_T]) begin
      if (is_fetch) begin
        seg_res = f_flt(FK_INSTR, C_NOEXEC, ea_q);
      end else begin
        case (cls_q)
          CLS_FLT:   seg_res = f_flt(FK_ALIGN, 32'h0, ea_q);
          CLS_RSV:   seg_res = f_flt(FK_DATA, dcode(C_RSV, is_store), ea_q);
          CLS_EXT:   seg_res = f_flt(FK_DATA, dcode(C_EXT, is_store), ea_q);
          CLS_CACHE: seg_res = f_ok(ea_q, ds_perm);
          default: begin
            if ((need & ~ds_perm) != 3'b000)
              seg_res = f_flt(FK_DATA, dcode(C_PROT, is_store), ea_q);
            else
              seg_res = f_ok(ea_q, ds_perm);
          end
        endcase
      end
    end else if (is_fetch && nx) begin
      seg_res = f_flt(FK_INSTR, C_NOEXEC, ea_q);
    end else begin
      seg_final = 1'b0;
    end

    // page-table outcome
    if (!walk_rsp_found)
      walk_res = is_fetch ? f_flt(FK_INSTR, C_MISS, ea_q)
                          : f_flt(FK_DATA, dcode(C_MISS, is_store), ea_q);
    else if ((need & ~pg_perm) != 3'b000)
      walk_res = is_fetch ? f_flt(FK_INSTR, C_PROT, ea_q)
                          : f_flt(FK_DATA, dcode(C_PROT, is_store), ea_q);
    else
      walk_res = f_ok({walk_rsp_rpn, ea_q[PG_BITS-1:0]},
                      (kind_q == ACC_LOAD && !walk_rsp_chg) ? (pg_perm & ~PM_W) : pg_perm);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      ea_q   <= '0;
      kind_q <= ACC_LOAD;
      user_q <= 1'b0;
      cls_q  <= CLS_INT;
      out_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            ea_q   <= req_ea;
            kind_q <= req_kind;
            user_q <= req_user;
            cls_q  <= req_class;
            if (!req_xlate_on) begin
              out_q  <= f_ok(req_ea, PM_R | PM_W | PM_X);
              done_q <= 1'b1;
            end else begin
              state <= ST_BLK;
            end
          end
        end
        ST_BLK: begin
          if (blk_rsp_valid) begin
            if (blk_rsp_hit) begin
              out_q  <= blk_res;
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else if (seg_final) begin
              out_q  <= seg_res;
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              state <= ST_WALK;
            end
          end
        end
        ST_WALK: begin
          if (walk_rsp_valid) begin
            out_q  <= walk_res;
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready      = (state == ST_IDLE);
  assign blk_req_valid  = (state == ST_BLK);
  assign blk_req_ea     = ea_q;
  assign blk_req_kind   = kind_q;
  assign blk_req_user   = user_q;
  assign walk_req_valid = (state == ST_WALK);
  assign walk_req_vsid  = seg_val[VSID_W-1:0];
  assign walk_req_ea    = ea_q;

  assign done     = done_q;
  assign ok       = out_q.ok;
  assign ra       = out_q.ra;
  assign perm     = out_q.perm;
  assign flt_kind = out_q.fk;
  assign flt_code = out_q.code;
  assign flt_addr = out_q.addr;

  p_done_single_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_busy_after_req_r12: assert property (@(posedge clk) disable iff (rst)
    $fell(req_ready) |-> $past(req_valid));

  p_walk_after_miss_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(walk_req_valid) |-> $past(blk_rsp_valid && !blk_rsp_hit));

  p_no_walk_noexec_r7: assert property (@(posedge clk) disable iff (rst)
    walk_req_valid |-> !(kind_q == ACC_FETCH && seg_val[SEG_NX]));

  p_data_fault_addr_r10: assert property (@(posedge clk) disable iff (rst)
    (done && flt_kind == FK_DATA) |-> (flt_addr == ea_q));

  p_ok_no_fault_r10: assert property (@(posedge clk) disable iff (rst)
    (done && ok) |-> (flt_kind == FK_NONE && flt_code == 32'h0));
endmodule

// File: tb/tb_xlate_seq.sv
module tb_xlate_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 24;

  typedef struct packed {
    logic [3:0]  rq;
    logic        xl;
    logic [1:0]  kind;
    logic [2:0]  cls;
    logic        usr;
    logic [31:0] ea;
    logic [31:0] seg;
    logic        bhit;
    logic [2:0]  bperm;
    logic [31:0] bra;
    logic        wf;
    logic [19:0] rpn;
    logic [1:0]  pp;
    logic        chg;
    logic        e_ok;
    logic [31:0] e_ra;
    logic [2:0]  e_perm;
    logic [1:0]  e_fk;
    logic [31:0] e_code;
    logic [31:0] e_addr;
  } vec_t;

  // kind 0 fetch 1 load 2 store; class 0 int 1 flt 2 rsv 3 cache 4 ext
  localparam vec_t VECS [NV] = '{
    // R1 translation off
    '{4'd1,1'b0,2'd1,3'd0,1'b0,32'h1234_5678,32'h0,1'b0,3'd0,32'h0,1'b0,20'h0,2'd0,1'b0, 1'b1,32'h1234_5678,3'd7,2'd0,32'h0,32'h0},
    // R2 block hit with rights
    '{4'd2,1'b1,2'd1,3'd0,1'b0,32'h2000_1004,32'h0,1'b1,3'd3,32'h0ABC_D004,1'b0,20'h0,2'd0,1'b0, 1'b1,32'h0ABC_D004,3'd3,2'd0,32'h0,32'h0},
    // R2 block hit, store denied
    '{4'd2,1'b1,2'd2,3'd0,1'b0,32'h2000_2000,32'h0,1'b1,3'd1,32'h0ABC_E000,1'b0,20'h0,2'd0,1'b0, 1'b0,32'h0,3'd0,2'd2,32'h0A00_0000,32'h2000_2000},
    // R2 block hit, fetch denied
    '{4'd2,1'b1,2'd0,3'd0,1'b0,32'h2000_3000,32'h0,1'b1,3'd1,32'h0ABC_F000,1'b0,20'h0,2'd0,1'b0, 1'b0,32'h0,3'd0,2'd1,32'h0800_0000,32'h0},
    // R4 direct-store fetch
    '{4'd4,1'b1,2'd0,3'd0,1'b0,32'h8000_0100,32'h8000_0000,1'b0,3'd0,32'h0,1'b0,20'h0,2'd0,1'b0, 1'b0,32'h0,3'd0,2'd1,32'h1000_0000,32'h0},
    // R4 direct-store floating
    '{4'd4,1'b1,2'd1,3'd1,1'b0,32'h8000_0200,32'h8000_0000,1'b0,3'd0,32'h0,1'b0,20'h0,2'd0,1'b0, 1'b0,32'h0,3'd0,2'd3,32'h0,32'h8000_0200},
    // R4 direct-store cache op
    '{4'd4,1'b1,2'd2,3'd3,1'b0,32'h8000_0300,32'h8000_0000,1'b0,3'd0,32'h0,1'b0,20'h0,2'd0,1'b0, 1'b1,32'h8000_0300,3'd1,2'd0,32'h0,32'h0},
    // R5 reservation store
    '{4'd5,1'b1,2'd2,3'd2,1'b0,32'h8000_0400,32'h8000_0000,1'b0,3'd0,32'h0,1'b0,20'h0,2'd0,1'b0, 1'b0,32'h0,3'd0,2'd2,32'h0600_0000,32'h8000_0400},
    // R5 external load
    '{4'd5,1'b1,2'd1,3'd4,1'b0,32'h8000_0500,32'h8000_0000,1'b0,3'd0,32'h0,1'b0,20'h0,2'd0,1'b0, 1'b0,32'h0,3'd0,2'd2,32'h0410_0000,32'h8000_0500},
    // R5 reservation load
    '{4'd5,1'b1,2'd1,3'd2,1'b0,32'h8000_0600,32'h8000_0000,1'b0,3'd0,32'h0,1'b0,20'h0,2'd0,1'b0, 1'b0,32'h0,3'd0,2'd2,32'h0400_0000,32'h8000_0600},
    // R5 external store
    '{4'd5,1'b1,2'd2,3'd4,1'b0,32'h8000_0700,32'h8000_0000,1'b0,3'd0,32'h0,1'b0,20'h0,2'd0,1'b0, 1'b0,32'h0,3'd0,2'd2,32'h0610_0000,32'h8000_0700},
    // R6 R3 user key 1, integer store granted
    '{4'd6,1'b1,2'd2,3'd0,1'b1,32'h9000_0010,32'hA000_0000,1'b0,3'd0,32'h0,1'b0,20'h0,2'd0,1'b0, 1'b1,32'h9000_0010,3'd3,2'd0,32'h0,32'h0},
    // R6 R3 supervisor key 0, integer store denied
    '{4'd6,1'b1,2'd2,3'd0,1'b0,32'h9000_0020,32'hA000_0000,1'b0,3'd0,32'h0,1'b0,20'h0,2'd0,1'b0, 1'b0,32'h0,3'd0,2'd2,32'h0A00_0000,32'h9000_0020},
    // R6 supervisor key 0, integer load read-only
    '{4'd6,1'b1,2'd1,3'd0,1'b0,32'h9000_0030,32'hA000_0000,1'b0,3'd0,32'h0,1'b0,20'h0,2'd0,1'b0, 1'b1,32'h9000_0030,3'd1,2'd0,32'h0,32'h0},
    // R7 no-execute fetch
    '{4'd7,1'b1,2'd0,3'd0,1'b0,32'h1000_0040,32'h1000_0000,1'b0,3'd0,32'h0,1'b1,20'h0,2'd0,1'b0, 1'b0,32'h0,3'd0,2'd1,32'h1000_0000,32'h0},
    // R9 miss store
    '{4'd9,1'b1,2'd2,3'd0,1'b0,32'h4000_0050,32'h0000_0123,1'b0,3'd0,32'h0,1'b0,20'h0,2'd0,1'b0, 1'b0,32'h0,3'd0,2'd2,32'h4200_0000,32'h4000_0050},
    // R9 miss fetch
    '{4'd9,1'b1,2'd0,3'd0,1'b0,32'h4000_0060,32'h0000_0123,1'b0,3'd0,32'h0,1'b0,20'h0,2'd0,1'b0, 1'b0,32'h0,3'd0,2'd1,32'h4000_0000,32'h0},
    // R8 key 0 pp 3 load
    '{4'd8,1'b1,2'd1,3'd0,1'b0,32'h3000_0ABC,32'h0000_0123,1'b0,3'd0,32'h0,1'b1,20'h55555,2'd3,1'b1, 1'b1,32'h5555_5ABC,3'd5,2'd0,32'h0,32'h0},
    // R8 R10 key 1 pp 0 load denied
    '{4'd8,1'b1,2'd1,3'd0,1'b1,32'h5000_0070,32'h2000_0000,1'b0,3'd0,32'h0,1'b1,20'h66666,2'd0,1'b1, 1'b0,32'h0,3'd0,2'd2,32'h0800_0000,32'h5000_0070},
    // R8 key 1 pp 2 store
    '{4'd8,1'b1,2'd2,3'd0,1'b1,32'h6000_0F00,32'h2000_0000,1'b0,3'd0,32'h0,1'b1,20'h11111,2'd2,1'b1, 1'b1,32'h1111_1F00,3'd7,2'd0,32'h0,32'h0},
    // R11 load on unchanged page loses write
    '{4'd11,1'b1,2'd1,3'd0,1'b0,32'h7000_0004,32'h0,1'b0,3'd0,32'h0,1'b1,20'h22222,2'd2,1'b0, 1'b1,32'h2222_2004,3'd5,2'd0,32'h0,32'h0},
    // R10 key 1 pp 1 store denied, no-execute segment
    '{4'd10,1'b1,2'd2,3'd0,1'b1,32'hB000_0008,32'h3000_0000,1'b0,3'd0,32'h0,1'b1,20'h77777,2'd1,1'b1, 1'b0,32'h0,3'd0,2'd2,32'h0A00_0000,32'hB000_0008},
    // R8 fetch key 1 pp 3
    '{4'd8,1'b1,2'd0,3'd0,1'b1,32'hC000_0010,32'h2000_0000,1'b0,3'd0,32'h0,1'b1,20'h33333,2'd3,1'b0, 1'b1,32'h3333_3010,3'd5,2'd0,32'h0,32'h0},
    // R8 fetch key 1 pp 0: execute only
    '{4'd8,1'b1,2'd0,3'd0,1'b1,32'hD000_0020,32'h2000_0000,1'b0,3'd0,32'h0,1'b1,20'h44444,2'd0,1'b1, 1'b1,32'h4444_4020,3'd4,2'd0,32'h0,32'h0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_ea = '0;
  logic [1:0]  req_kind = '0;
  logic        req_user = 1'b0, req_xlate_on = 1'b0;
  logic [2:0]  req_class = '0;
  logic        seg_we = 1'b0;
  logic [3:0]  seg_idx = '0;
  logic [31:0] seg_wdata = '0;
  logic        blk_req_valid, blk_req_user;
  logic [31:0] blk_req_ea;
  logic [1:0]  blk_req_kind;
  logic        blk_rsp_valid = 1'b0, blk_rsp_hit = 1'b0;
  logic [31:0] blk_rsp_ra = '0;
  logic [2:0]  blk_rsp_perm = '0;
  logic        walk_req_valid;
  logic [27:0] walk_req_vsid;
  logic [31:0] walk_req_ea;
  logic        walk_rsp_valid = 1'b0, walk_rsp_found = 1'b0, walk_rsp_chg = 1'b0;
  logic [19:0] walk_rsp_rpn = '0;
  logic [1:0]  walk_rsp_pp = '0;
  logic        done, ok;
  logic [31:0] ra, flt_code, flt_addr;
  logic [2:0]  perm;
  logic [1:0]  flt_kind;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit walk_seen;
  bit ready_low;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlate_seq dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_ea(req_ea), .req_kind(req_kind),
    .req_user(req_user), .req_xlate_on(req_xlate_on), .req_class(req_class),
    .seg_we(seg_we), .seg_idx(seg_idx), .seg_wdata(seg_wdata),
    .blk_req_valid(blk_req_valid), .blk_req_ea(blk_req_ea), .blk_req_kind(blk_req_kind),
    .blk_req_user(blk_req_user), .blk_rsp_valid(blk_rsp_valid), .blk_rsp_hit(blk_rsp_hit),
    .blk_rsp_ra(blk_rsp_ra), .blk_rsp_perm(blk_rsp_perm),
    .walk_req_valid(walk_req_valid), .walk_req_vsid(walk_req_vsid), .walk_req_ea(walk_req_ea),
    .walk_rsp_valid(walk_rsp_valid), .walk_rsp_found(walk_rsp_found), .walk_rsp_rpn(walk_rsp_rpn),
    .walk_rsp_pp(walk_rsp_pp), .walk_rsp_chg(walk_rsp_chg),
    .done(done), .ok(ok), .ra(ra), .perm(perm), .flt_kind(flt_kind),
    .flt_code(flt_code), .flt_addr(flt_addr)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R12: act=hung exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit cond, input int rq, input string what,
                     input logic [103:0] act, input logic [103:0] exp);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL R%0d %s: act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    logic [103:0] act, exp;
    @(negedge clk);
    seg_we    = 1'b1;
    seg_idx   = v.ea[31:28];
    seg_wdata = v.seg;
    @(negedge clk);
    seg_we       = 1'b0;
    req_valid    = 1'b1;
    req_ea       = v.ea;
    req_kind     = v.kind;
    req_class    = v.cls;
    req_user     = v.usr;
    req_xlate_on = v.xl;
    blk_rsp_hit  = v.bhit;
    blk_rsp_perm = v.bperm;
    blk_rsp_ra   = v.bra;
    walk_rsp_found = v.wf;
    walk_rsp_rpn   = v.rpn;
    walk_rsp_pp    = v.pp;
    walk_rsp_chg   = v.chg;
    walk_seen = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    if (v.xl && req_ready) ready_low = 1'b0;
    for (int i = 0; i < 50; i++) begin
      blk_rsp_valid  = 1'b0;
      walk_rsp_valid = 1'b0;
      if (done) break;
      if (blk_req_valid) blk_rsp_valid = 1'b1;
      if (walk_req_valid) begin
        walk_rsp_valid = 1'b1;
        walk_seen = 1'b1;
      end
      @(negedge clk);
    end
    act = {ok, ra, perm, 2'b00, flt_kind, flt_code, flt_addr[31:0]} >> 0;
    exp = {v.e_ok, v.e_ra, v.e_perm, 2'b00, v.e_fk, v.e_code, v.e_addr} >> 0;
    chk(done && (act == exp), int'(v.rq), "result {ok,ra,perm,fk,code,addr}", act, exp);
  endtask

  initial begin
    ready_low = 1'b1;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(req_ready && !done && !blk_req_valid && !walk_req_valid && flt_kind == 2'd0,
        12, "reset state", {100'd0, req_ready, done, blk_req_valid, walk_req_valid},
        {100'd0, 4'b1000});
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      run_vec(VECS[k]);
      if (k == 14) // R7: no walk on no-execute fetch
        chk(!walk_seen, 7, "walk requested", {103'd0, walk_seen}, 104'd0);
      if (k == 17) // R8: walk was used for page path
        chk(walk_seen, 8, "walk not requested", {103'd0, walk_seen}, 104'd1);
    end

    // R12 ready low while busy
    chk(ready_low, 12, "ready while busy", {103'd0, ready_low}, 104'd1);

    // R12 outputs hold after the done pulse
    repeat (3) @(negedge clk);
    chk(!done && ok && ra == 32'h4444_4020 && perm == 3'd4, 12, "hold",
        {67'd0, done, ok, ra, perm}, {67'd0, 1'b0, 1'b1, 32'h4444_4020, 3'd4});

    // R1 second pattern: store with translation off, user
    run_vec('{4'd1,1'b1 ^ 1'b1,2'd2,3'd2,1'b1,32'hFFFF_FFFC,32'h8000_0000,1'b0,3'd0,32'h0,1'b0,20'h0,2'd0,1'b0,
              1'b1,32'hFFFF_FFFC,3'd7,2'd0,32'h0,32'h0});

    // R12 reset during an outstanding request
    @(negedge clk);
    seg_we = 1'b0;
    req_valid = 1'b1; req_xlate_on = 1'b1; req_kind = 2'd1; req_ea = 32'h0000_1000;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(req_ready && !blk_req_valid && !walk_req_valid && !done && flt_kind == 2'd0,
        12, "reset mid-request", {100'd0, req_ready, blk_req_valid, walk_req_valid, done},
        {100'd0, 4'b1000});
    rst = 1'b0;
    repeat (2) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule